// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block turns two independent PWM command inputs into the enable signals for the upper and lower switches of a half-bridge. It guarantees that the two enables are never high together, inserts a programmable dead time between one enable dropping and the other rising, and holds both enables low while the commands overlap. Two level inputs force both enables low: a disable request and a supply-good flag that stands in for undervoltage lockout on the command side.

Every command input is first re-timed by a two-flop synchronizer, so each output change follows its cause by a fixed latency. The dead time is given directly as a count of clock cycles. It is counted from the cycle in which the opposite enable really fell, so a slow command swap gets credit for the gap it already has.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `gate_hi_out` and `gate_lo_out` are never high in the same cycle.
- R2: With no dead-time wait pending, a change on a command input appears on its enable at the third rising clock edge after the input changes. A command going low always drops its enable at that edge.
- R3: With a dead-time setting of N, an enable whose command is already high rises exactly N+1 clock edges after the edge on which the opposite enable fell, and not before.
- R4: If the opposite enable has already been low for at least N+1 edges when a command rises, the enable rises with only the R2 latency.
- R5: While both commands are high, both enables are low. An enable that was high is pulled low at the R2 latency.
- R6: After an overlap clears, the dead time runs from the edge on which the opposite enable fell, not from the clearing of the overlap.
- R7: A high `disable_in` forces both enables low at the R2 latency. A low `disable_in` allows normal operation.
- R8: A low `supply_ok_in` forces both enables low whatever the level of `disable_in`. Normal operation resumes when it returns high.
- R9: A setting of 0 lets the waiting enable rise on the edge right after the opposite enable fell.
- R10: The active-low synchronous reset drives both enables low. It leaves both dead-time counters expired, so the first enable after reset rises with only the R2 latency, whatever the setting.
- R11: `dead_cycles` is 10 bits wide, and the dead time scales linearly up to the maximum of 1023, which gives 1024 edges with both enables low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_a_in | input | 1 | Command for the upper switch (asynchronous) |
| pwm_b_in | input | 1 | Command for the lower switch (asynchronous) |
| disable_in | input | 1 | High forces both enables low |
| supply_ok_in | input | 1 | Low (lockout) forces both enables low |
| dead_cycles | input | 10 | Dead time in clock cycles |
| gate_hi_out | output | 1 | Enable for the upper switch |
| gate_lo_out | output | 1 | Enable for the lower switch |

## Verification
The assertions check four things on every cycle: the two enables are never high together, an enable only rises when its own counter has expired and the opposite enable was low, an overlap or a forced-off condition clears both enables on the next edge, and each counter reloads and saturates as intended. Some properties only the bench's scenarios can show: the exact edge on which an enable rises for a given setting, the credit given for a natural gap, the timing that follows an overlap, and the expired counters after reset. For these the bench drives command sequences and compares the enables against edge counts it works out from the requirements.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  // Synchronized view of the asynchronous control inputs
  typedef struct packed {
    logic pwm_a;
    logic pwm_b;
    logic dis;
    logic pgood;
  } hb_in_t;

  localparam int HB_IN_W = $bits(hb_in_t);

  // Forced-off rule: lockout wins, disable acts while supply is good
  function automatic logic drive_enabled(input hb_in_t s);
    return s.pgood & ~s.dis;
  endfunction

  // Enable rule for one channel
  function automatic logic gate_permit(input logic own_cmd,
                                       input logic other_cmd,
                                       input logic other_gate,
                                       input logic wait_done,
                                       input logic run_ok);
    return own_cmd & ~other_cmd & ~other_gate & wait_done & run_ok;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] load_val,
  output logic            expired
);

  logic [DT_W-1:0] count_q;

  // Reload on the opposite enable falling, otherwise count down and stop at zero
  function automatic logic [DT_W-1:0] next_count(input logic            ld,
                                                 input logic [DT_W-1:0] val,
                                                 input logic [DT_W-1:0] cur);
    if (ld)            return val;
    else if (cur != 0) return cur - 1'b1;
    else               return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= next_count(load, load_val, count_q);
  end

  assign expired = (count_q == '0);

  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(load_val)); // R3

  AST_TIMER_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R4

endmodule

// File: rtl/hb_gate_chan.sv
module hb_gate_chan
  import hb_dt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own_cmd,
  input  logic other_cmd,
  input  logic other_gate,
  input  logic wait_done,
  input  logic run_ok,
  output logic gate_q,
  output logic gate_fall
);

  logic gate_d;

  assign gate_d    = gate_permit(own_cmd, other_cmd, other_gate, wait_done, run_ok);
  assign gate_fall = gate_q & ~gate_d;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  AST_DROP_ON_CMD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !own_cmd |=> !gate_q); // R2

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter int DT_W        = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_a_in,
  input  logic            pwm_b_in,
  input  logic            disable_in,
  input  logic            supply_ok_in,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            gate_hi_out,
  output logic            gate_lo_out
);

  localparam int NCH = 2;

  hb_in_t            raw_in;
  hb_in_t            syn_in;
  logic [HB_IN_W-1:0] syn_vec;
  logic              run_ok;
  logic [NCH-1:0]    cmd_s;
  logic [NCH-1:0]    gate_q;
  logic [NCH-1:0]    gate_fall;
  logic [NCH-1:0]    wait_done;

  assign raw_in = '{pwm_a: pwm_a_in, pwm_b: pwm_b_in, dis: disable_in, pgood: supply_ok_in};

  hb_sync #(.WIDTH(HB_IN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .q_out (syn_vec)
  );

  assign syn_in = hb_in_t'(syn_vec);
  assign run_ok = drive_enabled(syn_in);
  assign cmd_s  = {syn_in.pwm_b, syn_in.pwm_a};

  // Channel 0 drives the upper switch, channel 1 the lower one
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int OTH = NCH - 1 - g;

    hb_dt_timer #(.DT_W(DT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gate_fall[OTH]),
      .load_val (dead_cycles),
      .expired  (wait_done[g])
    );

    hb_gate_chan chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .own_cmd    (cmd_s[g]),
      .other_cmd  (cmd_s[OTH]),
      .other_gate (gate_q[OTH]),
      .wait_done  (wait_done[g]),
      .run_ok     (run_ok),
      .gate_q     (gate_q[g]),
      .gate_fall  (gate_fall[g])
    );
  end

  assign gate_hi_out = gate_q[0];
  assign gate_lo_out = gate_q[1];

  AST_NEVER_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_out && gate_lo_out)); // R1

  AST_HI_RISE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_out) |-> ($past(wait_done[0]) && !$past(gate_lo_out))); // R3

  AST_LO_RISE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_out) |-> ($past(wait_done[1]) && !$past(gate_hi_out))); // R3

  AST_OVERLAP_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_in.pwm_a && syn_in.pwm_b) |=> (!gate_hi_out && !gate_lo_out)); // R5

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    syn_in.dis |=> (!gate_hi_out && !gate_lo_out)); // R7

  AST_LOCKOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_in.pgood |=> (!gate_hi_out && !gate_lo_out)); // R8

endmodule

// File: tb/hb_deadtime_ctrl_tb_top.sv
module hb_deadtime_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int DT_W  = 10;
  localparam int NV    = 26;

  // Vector: {dt[9:0], a, b, dis, pgood, wait[7:0], exp_hi, exp_lo, req[3:0]}
  // Inputs are applied, "wait" edges pass, then the enables are compared.
  localparam logic [27:0] VEC [NV] = '{
    {10'd5, 4'b1001, 8'd2,  2'b00, 4'd2},   // R2 not before third edge
    {10'd5, 4'b1001, 8'd1,  2'b10, 4'd10},  // R10 first rise after reset
    {10'd5, 4'b0101, 8'd2,  2'b10, 4'd2},   // R2 fall not yet
    {10'd5, 4'b0101, 8'd1,  2'b00, 4'd3},   // R3 upper falls
    {10'd5, 4'b0101, 8'd4,  2'b00, 4'd3},   // R3 still waiting
    {10'd5, 4'b0101, 8'd1,  2'b00, 4'd3},   // R3 one edge short
    {10'd5, 4'b0101, 8'd1,  2'b01, 4'd3},   // R3 rises at N+1
    {10'd5, 4'b0001, 8'd3,  2'b00, 4'd4},   // R4 lower drops
    {10'd5, 4'b0001, 8'd10, 2'b00, 4'd4},   // R4 natural gap
    {10'd5, 4'b1001, 8'd3,  2'b10, 4'd4},   // R4 immediate rise
    {10'd5, 4'b1101, 8'd3,  2'b00, 4'd5},   // R5 upper pulled low
    {10'd5, 4'b1101, 8'd2,  2'b00, 4'd5},   // R5 held during overlap
    {10'd5, 4'b0101, 8'd3,  2'b00, 4'd6},   // R6 still waiting
    {10'd5, 4'b0101, 8'd1,  2'b01, 4'd6},   // R6 N+1 from actual fall
    {10'd5, 4'b1101, 8'd3,  2'b00, 4'd5},   // R5 lower pulled low
    {10'd5, 4'b1101, 8'd10, 2'b00, 4'd5},   // R5 long overlap
    {10'd5, 4'b1001, 8'd3,  2'b10, 4'd6},   // R6 immediate after clear
    {10'd5, 4'b1011, 8'd2,  2'b10, 4'd7},   // R7 latency
    {10'd5, 4'b1011, 8'd1,  2'b00, 4'd7},   // R7 forced off
    {10'd5, 4'b0111, 8'd10, 2'b00, 4'd7},   // R7 stays off
    {10'd5, 4'b0101, 8'd3,  2'b01, 4'd7},   // R7 released
    {10'd5, 4'b0100, 8'd3,  2'b00, 4'd8},   // R8 lockout
    {10'd5, 4'b0110, 8'd10, 2'b00, 4'd8},   // R8 lockout with disable
    {10'd5, 4'b0101, 8'd3,  2'b01, 4'd8},   // R8 recovery
    {10'd0, 4'b1001, 8'd3,  2'b00, 4'd9},   // R9 lower drops
    {10'd0, 4'b1001, 8'd1,  2'b10, 4'd9}    // R9 next edge
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            pwm_a, pwm_b, dis, pgood;
  logic [DT_W-1:0] dt;
  logic            gate_hi, gate_lo;

  int n_checks = 0;
  int n_fails  = 0;
  int both_on  = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_deadtime_ctrl #(.DT_W(DT_W), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_a_in     (pwm_a),
    .pwm_b_in     (pwm_b),
    .disable_in   (dis),
    .supply_ok_in (pgood),
    .dead_cycles  (dt),
    .gate_hi_out  (gate_hi),
    .gate_lo_out  (gate_lo)
  );

  // R1 monitor
  always @(negedge clk) if (rst_n === 1'b1 && gate_hi && gate_lo) both_on++;

  task automatic check(input string req, input logic hi_exp, input logic lo_exp);
    n_checks++;
    if (gate_hi !== hi_exp || gate_lo !== lo_exp) begin
      n_fails++;
      $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t",
               req, gate_hi, gate_lo, hi_exp, lo_exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwm_a = 1'b0; pwm_b = 1'b0; dis = 1'b0; pgood = 1'b1; dt = 10'd5;
    edges(3);
    check("R10", 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      dt    = VEC[v][27:18];
      pwm_a = VEC[v][17];
      pwm_b = VEC[v][16];
      dis   = VEC[v][15];
      pgood = VEC[v][14];
      edges(int'(VEC[v][13:6]));
      check($sformatf("R%0d", VEC[v][3:0]), VEC[v][5], VEC[v][4]);
    end

    // R11: maximum setting, lower rises 4 + 1023 edges after the swap
    begin
      int cnt = 0;
      dt = 10'd1023; pwm_a = 1'b0; pwm_b = 1'b1;
      while (!gate_lo && cnt < 3000) begin
        @(negedge clk);
        cnt++;
      end
      n_checks++;
      if (cnt != 1027) begin
        n_fails++;
        $display("FAIL R11: rise after %0d edges expected %0d", cnt, 1027);
      end
    end

    // R10: reset mid-run clears enables and leaves counters expired
    rst_n = 1'b0;
    edges(1);
    check("R10", 1'b0, 1'b0);
    edges(2);
    rst_n = 1'b1;
    edges(2);
    check("R10", 1'b0, 1'b0);
    edges(1);
    check("R10", 1'b0, 1'b1);

    n_checks++;
    if (both_on != 0) begin
      n_fails++;
      $display("FAIL R1: both enables high in %0d cycles expected 0", both_on);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule